// File: doc/BRIEF.md
# Accumulator Read/Write Formatter for a Multiply-Accumulate Unit

This block holds four 48-bit accumulators and their per-accumulator sticky overflow bits. It moves values between these accumulators and a 32-bit register interface. A read request picks one accumulator and formats it into a 32-bit word. The formatting depends on the mode bits:

- **Fractional mode:** the value is rounded and clipped to a 16-bit or 32-bit fraction.
- **Integer mode:** the value is passed through or clipped to a signed or unsigned 32-bit word.

A read may also clear the accumulator it reads. A write request takes a 32-bit word and places it into one accumulator at the position the current mode defines.

The mode is a small register loaded through `cfg_we`. It has four bits:

- fractional
- signed
- saturate (the overflow-mode control)
- round

The fractional layout keeps the 32-bit core at bits 39..8 and the low extension byte at bits 7..0. The integer layout keeps the core at bits 31..0 and the low extension byte at bits 39..32. In both layouts bits 47..40 hold the high extension byte. When a mode load changes the fractional or the signed bit, every accumulator is re-packed from the old layout into the new one, so that its value keeps its meaning.

The multiply and accumulate arithmetic sit outside this block. They see the accumulators on `acc_flat`, and they raise sticky bits through `sticky_set`.

Top module: `mac_acc_fmt`

## Requirements
- R1: `rd_valid` rises exactly one clock after `rd_req`, and `rd_data` then holds the formatted value. The formatting uses the accumulator contents and mode in force before that clock edge.
- R2: A read with fractional=1 and signed=1 treats accumulator bits 47..24 as a signed number. It rounds that number half-to-even on bits 23..0, where 0x800000 is the exact halfway point. It returns the low 16 bits of the result in `rd_data[15:0]`, with `rd_data[31:16]` zero.
- R3: A read with fractional=1 and signed=0 shifts the accumulator arithmetically right by 8. If round=1, it rounds half-to-even on the dropped byte, where 0x80 is the halfway point. It returns the low 32 bits.
- R4: In the fractional reads of R2 and R3 with saturate=1, a rounded value that does not fit is clipped. In 16-bit form it clips to 0x7FFF or 0x8000; in 32-bit form it clips to 0x7FFFFFFF or 0x80000000.
- R5: A read with fractional=0 and saturate=0 returns accumulator bits 31..0 unchanged.
- R6: A read with fractional=0 and saturate=1 clips to a 32-bit word:
  - with signed=1, it returns 0x7FFFFFFF or 0x80000000 when the value is outside the signed 32-bit range;
  - with signed=0, it returns 0xFFFFFFFF when any of bits 47..32 is set.
- R7: A read with `rd_clr`=1 zeroes the selected accumulator and its sticky bit at the same edge. A write to the same index in that cycle takes precedence.
- R8: A write places the word into the selected accumulator and clears that accumulator's sticky bit:
  - fractional mode: the word, sign-extended and shifted left by 8;
  - signed mode: the word, sign-extended to 48 bits;
  - otherwise: the word, zero-extended to 48 bits.
- R9: A mode load that changes the fractional or signed bit re-packs each accumulator. It keeps bits 47..40 and moves the 32-bit core and the low extension byte from the old layout to the new one. When the fractional bit is unchanged, the contents stay as they are.
- R10: When a mode load and a write fall in the same cycle, the re-pack happens first. The write then uses the new mode and overwrites its target accumulator.
- R11: `sticky_set[i]` sets sticky bit i unless a write or clear to accumulator i happens in the same cycle. An accumulator with no write, clear or mode load in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the mode register from the four cfg bits |
| cfg_frac | input | 1 | New fractional mode bit |
| cfg_sgn | input | 1 | New signed mode bit |
| cfg_sat | input | 1 | New saturate bit |
| cfg_rnd | input | 1 | New round bit |
| rd_req | input | 1 | Read request |
| rd_idx | input | IDX_W | Accumulator index to read |
| rd_clr | input | 1 | Clear the read accumulator after the read |
| rd_valid | output | 1 | Read data valid, one clock after the request |
| rd_data | output | 32 | Formatted read result |
| wr_req | input | 1 | Write request |
| wr_idx | input | IDX_W | Accumulator index to write |
| wr_data | input | 32 | Word to place |
| sticky_set | input | NUM_ACC | Sticky overflow set pulses from the arithmetic |
| acc_flat | output | NUM_ACC*48 | All accumulators, accumulator i at bits i*48 upward |
| sticky | output | NUM_ACC | Sticky overflow bits |

## Verification
The case that needs the most care is a mode load and a write landing in the same cycle. The write must be placed using the new layout, onto an accumulator that has just been re-packed. Random stimulus issues mode loads, writes and clear-reads freely in the same cycles, and directed steps pair a fractional-to-integer mode load with a write to a single index. Each cycle the bench compares all four accumulators and the sticky bits against its own model, which applies the re-pack first and the write second.

// File: rtl/mac_fmt_pkg.sv
package mac_fmt_pkg;

  localparam int ACC_W  = 48;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic frac;
    logic sgn;
    logic sat;
    logic rnd;
  } mac_mode_t;

  // all-ones or all-zeros test for a sign-run
  function automatic logic sign_run(input logic [9:0] s);
    return (&s) | (~|s);
  endfunction

  // Format one accumulator for the register interface.
  function automatic logic [DATA_W-1:0] fmt_read(input logic [ACC_W-1:0] v,
                                                 input mac_mode_t m);
    logic [24:0] q16;
    logic [40:0] q32;
    logic        up;
    logic [DATA_W-1:0] r;
    if (m.frac && m.sgn) begin
      up  = (v[23:0] > 24'h800000) || ((v[23:0] == 24'h800000) && v[24]);
      q16 = {v[47], v[47:24]} + {24'd0, up};
      if (m.sat && !sign_run(q16[24:15]))
        r = q16[24] ? 32'h0000_8000 : 32'h0000_7FFF;
      else
        r = {16'd0, q16[15:0]};
    end else if (m.frac) begin
      up  = m.rnd && ((v[7:0] > 8'h80) || ((v[7:0] == 8'h80) && v[8]));
      q32 = {v[47], v[47:8]} + {40'd0, up};
      if (m.sat && !sign_run(q32[40:31]))
        r = q32[40] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else
        r = q32[31:0];
    end else if (!m.sat) begin
      r = v[31:0];
    end else if (m.sgn) begin
      if (!((&v[47:31]) | (~|v[47:31])))
        r = v[47] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else
        r = v[31:0];
    end else begin
      r = (|v[47:32]) ? 32'hFFFF_FFFF : v[31:0];
    end
    return r;
  endfunction

  // Place a register word into accumulator form.
  function automatic logic [ACC_W-1:0] fmt_write(input logic [DATA_W-1:0] w,
                                                 input logic frac,
                                                 input logic sgn);
    if (frac)     return {{8{w[31]}}, w, 8'h00};
    else if (sgn) return {{16{w[31]}}, w};
    else          return {16'h0000, w};
  endfunction

  // Move core and low extension byte between layouts.
  function automatic logic [ACC_W-1:0] repack(input logic [ACC_W-1:0] a,
                                              input logic old_frac,
                                              input logic new_frac);
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [31:0] core;
    hi = a[47:40];
    if (old_frac) begin core = a[39:8];  lo = a[7:0];   end
    else          begin core = a[31:0];  lo = a[39:32]; end
    return new_frac ? {hi, core, lo} : {hi, lo, core};
  endfunction

endpackage

// File: rtl/mac_fmt_lane.sv
module mac_fmt_lane
  import mac_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             repack_fire,
  input  logic             old_frac,
  input  logic             new_frac,
  input  logic             wr_hit,
  input  logic [ACC_W-1:0] wr_word,
  input  logic             clr_hit,
  input  logic             set_in,
  output logic [ACC_W-1:0] acc_q,
  output logic             sticky_q
);

  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    base = repack_fire ? repack(acc_q, old_frac, new_frac) : acc_q;
    if (wr_hit)       acc_d = wr_word;
    else if (clr_hit) acc_d = '0;
    else              acc_d = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      sticky_q <= (wr_hit || clr_hit) ? 1'b0 : (sticky_q | set_in);
    end
  end

endmodule

// File: rtl/mac_fmt_read.sv
module mac_fmt_read
  import mac_fmt_pkg::*;
(
  input  logic [ACC_W-1:0]  acc,
  input  mac_mode_t         mode,
  output logic [DATA_W-1:0] word
);

  always_comb word = fmt_read(acc, mode);

endmodule

// File: rtl/mac_acc_fmt.sv
module mac_acc_fmt
  import mac_fmt_pkg::*;
#(
  parameter  int NUM_ACC = 4,
  localparam int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_frac,
  input  logic                     cfg_sgn,
  input  logic                     cfg_sat,
  input  logic                     cfg_rnd,
  input  logic                     rd_req,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic                     rd_clr,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_req,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_ACC-1:0]       sticky_set,
  output logic [NUM_ACC*ACC_W-1:0] acc_flat,
  output logic [NUM_ACC-1:0]       sticky
);

  mac_mode_t        mode_q;
  mac_mode_t        mode_nxt;
  logic             repack_fire;
  logic [ACC_W-1:0] wr_word;
  logic [ACC_W-1:0] acc_arr [NUM_ACC];
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    mode_nxt    = cfg_we ? '{frac: cfg_frac, sgn: cfg_sgn, sat: cfg_sat, rnd: cfg_rnd}
                         : mode_q;
    repack_fire = cfg_we && ((cfg_frac != mode_q.frac) || (cfg_sgn != mode_q.sgn));
    wr_word     = fmt_write(wr_data, mode_nxt.frac, mode_nxt.sgn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_nxt;
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_lane
    mac_fmt_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .repack_fire(repack_fire),
      .old_frac   (mode_q.frac),
      .new_frac   (mode_nxt.frac),
      .wr_hit     (wr_req && (wr_idx == IDX_W'(i))),
      .wr_word    (wr_word),
      .clr_hit    (rd_req && rd_clr && (rd_idx == IDX_W'(i))),
      .set_in     (sticky_set[i]),
      .acc_q      (acc_arr[i]),
      .sticky_q   (sticky[i])
    );
    assign acc_flat[i*ACC_W +: ACC_W] = acc_arr[i];
  end

  mac_fmt_read u_read (
    .acc (acc_arr[rd_idx]),
    .mode(mode_q),
    .word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_word;
    end
  end

endmodule

// File: rtl/mac_acc_fmt_chk.sv
module mac_acc_fmt_chk
  import mac_fmt_pkg::*;
#(
  parameter  int NUM_ACC = 4,
  localparam int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     cfg_frac,
  input logic                     cur_frac,
  input logic                     rd_req,
  input logic [IDX_W-1:0]         rd_idx,
  input logic                     rd_clr,
  input logic                     rd_valid,
  input logic                     wr_req,
  input logic [IDX_W-1:0]         wr_idx,
  input logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input logic [NUM_ACC-1:0]       sticky
);

  logic [ACC_W-1:0] accs [NUM_ACC];
  for (genvar i = 0; i < NUM_ACC; i++) begin : g_unpack
    assign accs[i] = acc_flat[i*ACC_W +: ACC_W];
  end

  logic clr_only;
  assign clr_only = rd_req && rd_clr && !(wr_req && (wr_idx == rd_idx));

  // R1
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R1
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R7
  clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_only |=> (accs[$past(rd_idx)] == '0) && !sticky[$past(rd_idx)]);

  // R8
  write_sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !sticky[$past(wr_idx)]);

  // R11
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !wr_req && !(rd_req && rd_clr)) |=> $stable(acc_flat));

  // R9
  layout_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_frac == cur_frac) && !wr_req && !(rd_req && rd_clr))
      |=> $stable(acc_flat));

endmodule

bind mac_acc_fmt mac_acc_fmt_chk #(.NUM_ACC(NUM_ACC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .cfg_frac(cfg_frac),
  .cur_frac(mode_q.frac),
  .rd_req  (rd_req),
  .rd_idx  (rd_idx),
  .rd_clr  (rd_clr),
  .rd_valid(rd_valid),
  .wr_req  (wr_req),
  .wr_idx  (wr_idx),
  .acc_flat(acc_flat),
  .sticky  (sticky)
);

// File: tb/mac_acc_fmt_tb.sv
module mac_acc_fmt_tb;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_frac = 0, cfg_sgn = 0, cfg_sat = 0, cfg_rnd = 0;
  logic rd_req = 0, rd_clr = 0, wr_req = 0;
  logic [1:0] rd_idx = 0, wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic [N-1:0] sticky_set = 0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [N*48-1:0] acc_flat;
  logic [N-1:0] sticky;

  always #10 clk = ~clk;

  mac_acc_fmt #(.NUM_ACC(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_frac(cfg_frac), .cfg_sgn(cfg_sgn),
    .cfg_sat(cfg_sat), .cfg_rnd(cfg_rnd),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_clr(rd_clr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .sticky_set(sticky_set), .acc_flat(acc_flat), .sticky(sticky)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [47:0] m_acc [N];
  logic [N-1:0] m_sticky;
  logic m_frac, m_sgn, m_sat, m_rnd;

  task automatic chk(input bit ok, input string tag,
                     input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] clamp32(input longint q);
    if (q > 64'sd2147483647)       return 32'h7FFF_FFFF;
    else if (q < -64'sd2147483648) return 32'h8000_0000;
    else                            return q[31:0];
  endfunction

  // Reference read formatting, restated with signed 64-bit arithmetic
  function automatic logic [31:0] ref_read(input logic [47:0] v,
      input logic f, input logic s, input logic sat, input logic rnd);
    longint x, q, rem;
    x = longint'($signed(v));
    if (f && s) begin
      q = x >>> 24; rem = x & 64'hFF_FFFF;
      if (rem > 64'h80_0000 || (rem == 64'h80_0000 && q[0])) q = q + 1;
      if (sat && q > 32767)  return 32'h0000_7FFF;
      if (sat && q < -32768) return 32'h0000_8000;
      return {16'h0, q[15:0]};
    end
    if (f) begin
      q = x >>> 8; rem = x & 64'hFF;
      if (rnd && (rem > 64'h80 || (rem == 64'h80 && q[0]))) q = q + 1;
      return sat ? clamp32(q) : q[31:0];
    end
    if (!sat) return v[31:0];
    if (s)    return clamp32(x);
    return (v >> 32) != 0 ? 32'hFFFF_FFFF : v[31:0];
  endfunction

  function automatic string read_tag(input logic f, input logic s, input logic sat);
    if (f && s) return sat ? "R1 R2 R4" : "R1 R2";
    if (f)      return sat ? "R1 R3 R4" : "R1 R3";
    if (!sat)   return "R1 R5";
    return "R1 R6";
  endfunction

  function automatic logic [47:0] ref_place(input logic [31:0] w, input logic f, input logic s);
    longint x;
    x = longint'($signed(w));
    if (f) return 48'(x * 256);
    if (s) return 48'(x);
    return 48'(w);
  endfunction

  function automatic logic [47:0] ref_repack(input logic [47:0] a, input logic of_, input logic nf);
    logic [63:0] hi, lo, core;
    hi = 64'(a) >> 40;
    core = of_ ? ((64'(a) >> 8) & 64'hFFFF_FFFF) : (64'(a) & 64'hFFFF_FFFF);
    lo   = of_ ? (64'(a) & 64'hFF) : ((64'(a) >> 32) & 64'hFF);
    return nf ? 48'((hi << 40) | (core << 8) | lo) : 48'((hi << 40) | (lo << 32) | core);
  endfunction

  // One cycle: drive at negedge, update model, check at next negedge
  task automatic step(input logic cw, input logic cf, input logic cs,
                      input logic csat, input logic crnd,
                      input logic w, input logic [1:0] wi, input logic [31:0] wd,
                      input logic r, input logic [1:0] ri, input logic rc,
                      input logic [N-1:0] ss);
    logic [31:0] exp_d;
    string rtag;
    logic [N*48-1:0] exp_flat;
    cfg_we = cw; cfg_frac = cf; cfg_sgn = cs; cfg_sat = csat; cfg_rnd = crnd;
    wr_req = w; wr_idx = wi; wr_data = wd;
    rd_req = r; rd_idx = ri; rd_clr = rc; sticky_set = ss;
    exp_d = ref_read(m_acc[ri], m_frac, m_sgn, m_sat, m_rnd);
    rtag  = read_tag(m_frac, m_sgn, m_sat);
    // R10: re-pack first, then write with the new mode
    if (cw) begin
      if (cf != m_frac || cs != m_sgn)
        for (int i = 0; i < N; i++) m_acc[i] = ref_repack(m_acc[i], m_frac, cf);
      m_frac = cf; m_sgn = cs; m_sat = csat; m_rnd = crnd;
    end
    for (int i = 0; i < N; i++) begin
      if (w && wi == 2'(i)) begin
        m_acc[i] = ref_place(wd, m_frac, m_sgn); m_sticky[i] = 1'b0;
      end else if (r && rc && ri == 2'(i)) begin
        m_acc[i] = '0; m_sticky[i] = 1'b0;
      end else begin
        m_sticky[i] = m_sticky[i] | ss[i];
      end
    end
    @(negedge clk);
    for (int i = 0; i < N; i++) exp_flat[i*48 +: 48] = m_acc[i];
    chk(acc_flat == exp_flat, "R7 R8 R9 R10 R11 accumulators", 192'(acc_flat), 192'(exp_flat));
    chk(sticky == m_sticky, "R7 R8 R11 sticky", 192'(sticky), 192'(m_sticky));
    chk(rd_valid == r, "R1 valid", 192'(rd_valid), 192'(r));
    if (r) chk(rd_data == exp_d, rtag, 192'(rd_data), 192'(exp_d));
  endtask

  task automatic idle();
    step(0,0,0,0,0, 0,0,0, 0,0,0, '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] corners [6];
    int unsigned seed;
    corners = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_8000,
                32'hFFFF_FFFF, 32'h0000_8000, 32'h0000_0080};
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) m_acc[i] = '0;
    m_sticky = '0; m_frac = 0; m_sgn = 0; m_sat = 0; m_rnd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk(acc_flat == '0, "R11 reset accumulators", 192'(acc_flat), 192'd0);
    chk(sticky == '0, "R7 reset sticky", 192'(sticky), 192'd0);
    chk(rd_valid == 1'b0, "R1 reset valid", 192'(rd_valid), 192'd0);

    // R8 R5: unsigned integer write, plain read
    step(0,0,0,0,0, 1,0,32'h8000_0000, 0,0,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,0,0, '0);
    // R9 R4: to fractional unsigned with saturate, 32-bit clip to 0x7FFFFFFF
    step(1,1,0,1,0, 0,0,0, 0,0,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,0,0, '0);
    chk(rd_data == 32'h7FFF_FFFF, "R4 directed 32-bit clip", 192'(rd_data), 192'h7FFF_FFFF);
    // R2 R4: signed fractional, halfway on odd rounds up then clips
    step(1,1,1,1,0, 1,1,32'h7FFF_8000, 0,0,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,1,0, '0);
    chk(rd_data == 32'h0000_7FFF, "R4 directed 16-bit clip", 192'(rd_data), 192'h7FFF);
    step(1,1,1,0,0, 0,0,0, 1,1,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,1,0, '0);
    chk(rd_data == 32'h0000_8000, "R2 directed halfway odd", 192'(rd_data), 192'h8000);
    step(0,0,0,0,0, 1,2,32'h7FFE_8000, 0,0,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,2,0, '0);
    chk(rd_data == 32'h0000_7FFE, "R2 directed halfway even", 192'(rd_data), 192'h7FFE);
    // R3: integer signed negative word, then fractional with rounding
    step(1,0,1,0,0, 1,3,32'hFFFF_FF00, 0,0,0, '0);
    step(1,1,0,0,1, 0,0,0, 0,0,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,3,0, '0);
    chk(rd_data == 32'hFFFF_FF01, "R3 directed round up", 192'(rd_data), 192'hFFFF_FF01);
    // R7: sticky set then clear-after-read
    step(0,0,0,0,0, 0,0,0, 0,0,0, 4'b1000);
    step(0,0,0,0,0, 0,0,0, 1,3,1, '0);
    // R10: mode load and write in the same cycle
    step(1,0,1,1,0, 1,0,32'h8000_0000, 0,0,0, '0);
    // R6: negative value from fractional layout read as integer
    step(1,1,1,0,0, 1,1,32'h8000_0000, 0,0,0, '0);
    step(1,0,1,1,0, 0,0,0, 0,0,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,1,0, '0);
    chk(rd_data == 32'h8000_0000, "R6 directed signed clip", 192'(rd_data), 192'h8000_0000);
    step(1,0,0,1,0, 0,0,0, 1,1,0, '0);
    step(0,0,0,0,0, 0,0,0, 1,1,0, '0);
    chk(rd_data == 32'hFFFF_FFFF, "R6 directed unsigned clip", 192'(rd_data), 192'hFFFF_FFFF);
    idle();

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] wd;
      wd = ($urandom % 3 == 0) ? corners[$urandom % 6] : $urandom;
      step(($urandom % 8) == 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 3) == 0, 2'($urandom), wd,
           ($urandom % 2) == 0, 2'($urandom), ($urandom % 4) == 0,
           (($urandom % 8) == 0) ? 4'($urandom) : 4'd0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule